// File: doc/BRIEF.md
# Host-Target Mailbox Command Port

This block is a single-address, memory-mapped mailbox that target software uses to pass commands to a host. It holds one 64-bit word. A store can be 1 to 8 bytes wide. It is zero-extended and latched. In the same cycle the word is split into a device field (bits 63..56), a command field (bits 55..48) and a 48-bit payload (bits 47..0), and the decoded action is carried out at once.

Two actions are defined. For device 0x00 with payload bit 0 set, the block raises a sticky exit-done flag and captures an exit code, which is the payload shifted right by one bit (47 bits). For device 0x01 with command 0x01, the block pulses a console strobe for one cycle and presents payload bits 7..0 as the console byte. Every other command is latched and causes no action.

A load returns the stored word, but only for an 8-byte access. A periodic platform tick zeroes the word. Software reads that zero as the host's acknowledgement.

Top module: `hostmbox_port`

## Requirements
- R1: After a synchronous reset, the stored word, exit_done, exit_code, con_valid, con_byte, rd_valid, rd_data and rd_fault are all zero.
- R2: A store with wr_size from 1 to 8 keeps the low wr_size bytes of wr_data and clears the upper bytes. The result is held as the stored word from the next cycle on.
- R3: rd_en with rd_size equal to 8 gives rd_valid=1, rd_fault=0 and rd_data equal to the stored word in the cycle after. Any other rd_size gives rd_valid=1, rd_fault=1 and rd_data=0. With no load, rd_valid, rd_fault and rd_data are 0.
- R4: A store whose device field (bits 63..56) is 0x00 and whose payload bit 0 (word bit 0) is 1 sets exit_done in the next cycle. The same store sets exit_code to word bits 47..1. With payload bit 0 at 0, exit_done and exit_code do not change.
- R5: A store with device 0x01 and command field (bits 55..48) 0x01 drives con_valid high for exactly the next cycle, with con_byte equal to word bits 7..0. Back-to-back such stores give one strobe cycle each.
- R6: A store with device 0x01 and command 0x00, device 0x01 with any other command, or any device other than 0x00 and 0x01 changes neither exit_done, exit_code nor con_valid. The word is still latched and can be read back.
- R7: A tick with no accepted store in the same cycle clears the stored word to zero. When a store and a tick fall in the same cycle, the store wins.
- R8: A store with wr_size 0 or above 8 is ignored. The stored word is unchanged and no exit or console action occurs.
- R9: exit_done stays 1 until reset. A later exit command replaces exit_code.
- R10: A load in the same cycle as a store returns the word held before that store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Store request |
| wr_size | input | 4 | Store width in bytes (1..8 valid) |
| wr_data | input | 64 | Store data, low bytes significant |
| rd_en | input | 1 | Load request |
| rd_size | input | 4 | Load width in bytes (only 8 succeeds) |
| tick | input | 1 | Platform tick; clears the word as acknowledgement |
| rd_valid | output | 1 | Load response present |
| rd_data | output | 64 | Load data (zero on fault) |
| rd_fault | output | 1 | Load access fault |
| exit_done | output | 1 | Sticky exit-requested flag |
| exit_code | output | 47 | Captured exit code |
| con_valid | output | 1 | One-cycle console output strobe |
| con_byte | output | 8 | Console output byte |

## Verification
Every result has a latency of one register. The word, exit_done, exit_code, the console strobe and the load response all take their new values at the clock edge that samples the request. The bench drives each request on a falling edge. It samples all outputs on the next falling edge and compares them with a bench model that it updates in the same order: first the load response from the old word, then the store or the tick. With this timing the same-cycle cases (a store with a tick, a store with a load) and back-to-back console strobes can be checked at a definite cycle.

// File: rtl/hostmbox_pkg.sv
package hostmbox_pkg;
  parameter int unsigned WORD_W = 64;
  parameter int unsigned DEV_W  = 8;
  parameter int unsigned CMD_W  = 8;
  parameter int unsigned CON_W  = 8;

  localparam int unsigned PAY_W  = WORD_W - DEV_W - CMD_W;
  localparam int unsigned BYTES  = WORD_W / 8;
  localparam int unsigned SIZE_W = $clog2(BYTES) + 1;
  localparam int unsigned CODE_W = PAY_W - 1;
  localparam int unsigned DEV_LO = WORD_W - DEV_W;
  localparam int unsigned CMD_LO = PAY_W;

  localparam logic [DEV_W-1:0] DEV_SYSPROXY = 8'h00;
  localparam logic [DEV_W-1:0] DEV_CONSOLE  = 8'h01;
  localparam logic [CMD_W-1:0] CON_GETC     = 8'h00;
  localparam logic [CMD_W-1:0] CON_PUTC     = 8'h01;

  typedef struct packed {
    logic              exit_req;
    logic [CODE_W-1:0] code;
    logic              con_req;
    logic [CON_W-1:0]  chr;
  } mbox_act_t;
endpackage

// File: rtl/hostmbox_store_fmt.sv
module hostmbox_store_fmt
  import hostmbox_pkg::*;
(
  input  logic [SIZE_W-1:0] size,
  input  logic [WORD_W-1:0] data,
  output logic [WORD_W-1:0] word,
  output logic              size_ok
);
  assign size_ok = (size != '0) && (size <= SIZE_W'(BYTES));

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    logic keep;
    assign keep = (SIZE_W'(b) < size);
    assign word[b*8 +: 8] = keep ? data[b*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/hostmbox_decode.sv
module hostmbox_decode
  import hostmbox_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output mbox_act_t         act
);
  logic [DEV_W-1:0] dev;
  logic [CMD_W-1:0] cmd;
  logic [PAY_W-1:0] pay;

  assign dev = word[DEV_LO +: DEV_W];
  assign cmd = word[CMD_LO +: CMD_W];
  assign pay = word[PAY_W-1:0];

  always_comb begin
    act          = '0;
    act.code     = pay[PAY_W-1:1];
    act.chr      = pay[CON_W-1:0];
    unique case (dev)
      DEV_SYSPROXY: act.exit_req = pay[0];
      DEV_CONSOLE: begin
        unique case (cmd)
          CON_PUTC: act.con_req = 1'b1;
          CON_GETC: act.con_req = 1'b0;
          default:  act.con_req = 1'b0;
        endcase
      end
      default: act = act;
    endcase
  end
endmodule

// File: rtl/hostmbox_latch.sv
module hostmbox_latch
  import hostmbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              st_fire,
  input  logic [WORD_W-1:0] st_word,
  input  logic              tick,
  input  logic              ld_en,
  input  logic [SIZE_W-1:0] ld_size,
  output logic [WORD_W-1:0] mbox_q,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_fault
);
  logic ld_full;
  assign ld_full = (ld_size == SIZE_W'(BYTES));

  always_ff @(posedge clk) begin
    if (rst) begin
      mbox_q <= '0;
    end else if (st_fire) begin
      mbox_q <= st_word;
    end else if (tick) begin
      mbox_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_fault <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= ld_en;
      rd_fault <= ld_en && !ld_full;
      rd_data  <= (ld_en && ld_full) ? mbox_q : '0;
    end
  end
endmodule

// File: rtl/hostmbox_actions.sv
module hostmbox_actions
  import hostmbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  mbox_act_t         act,
  output logic              exit_done,
  output logic [CODE_W-1:0] exit_code,
  output logic              con_valid,
  output logic [CON_W-1:0]  con_byte
);
  always_ff @(posedge clk) begin
    if (rst) begin
      exit_done <= 1'b0;
      exit_code <= '0;
    end else if (fire && act.exit_req) begin
      exit_done <= 1'b1;
      exit_code <= act.code;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      con_valid <= 1'b0;
      con_byte  <= '0;
    end else begin
      con_valid <= fire && act.con_req;
      if (fire && act.con_req) con_byte <= act.chr;
    end
  end
endmodule

// File: rtl/hostmbox_port.sv
module hostmbox_port
  import hostmbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SIZE_W-1:0] wr_size,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [SIZE_W-1:0] rd_size,
  input  logic              tick,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_fault,
  output logic              exit_done,
  output logic [CODE_W-1:0] exit_code,
  output logic              con_valid,
  output logic [CON_W-1:0]  con_byte
);
  logic [WORD_W-1:0] st_word;
  logic              size_ok;
  logic              st_fire;
  logic [WORD_W-1:0] mbox_q;
  mbox_act_t         act;

  assign st_fire = wr_en && size_ok;

  hostmbox_store_fmt u_fmt (
    .size    (wr_size),
    .data    (wr_data),
    .word    (st_word),
    .size_ok (size_ok)
  );

  hostmbox_decode u_dec (
    .word (st_word),
    .act  (act)
  );

  hostmbox_latch u_latch (
    .clk      (clk),
    .rst      (rst),
    .st_fire  (st_fire),
    .st_word  (st_word),
    .tick     (tick),
    .ld_en    (rd_en),
    .ld_size  (rd_size),
    .mbox_q   (mbox_q),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .rd_fault (rd_fault)
  );

  hostmbox_actions u_act (
    .clk       (clk),
    .rst       (rst),
    .fire      (st_fire),
    .act       (act),
    .exit_done (exit_done),
    .exit_code (exit_code),
    .con_valid (con_valid),
    .con_byte  (con_byte)
  );
endmodule

// File: rtl/hostmbox_chk.sv
module hostmbox_chk
  import hostmbox_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [SIZE_W-1:0] wr_size,
  input logic [WORD_W-1:0] wr_data,
  input logic              rd_en,
  input logic [SIZE_W-1:0] rd_size,
  input logic              tick,
  input logic              rd_valid,
  input logic              rd_fault,
  input logic              exit_done,
  input logic              con_valid,
  input logic [CON_W-1:0]  con_byte,
  input logic [WORD_W-1:0] mbox_q
);
  logic good_size;
  logic term_put;
  assign good_size = (wr_size != '0) && (wr_size <= SIZE_W'(BYTES));
  assign term_put  = wr_en && good_size && (wr_size > 6) &&
                     (wr_data[DEV_LO +: DEV_W] == DEV_CONSOLE) &&
                     (wr_data[CMD_LO +: CMD_W] == CON_PUTC);

  // R5: every strobe comes from a console write one cycle earlier
  assert_con_cause_R5: assert property (@(posedge clk) disable iff (rst)
    con_valid |-> ($past(term_put) && con_byte == $past(wr_data[CON_W-1:0])));

  // R9: exit flag is sticky
  assert_exit_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    exit_done |=> exit_done);

  // R3: narrow loads fault
  assert_narrow_fault_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_size != SIZE_W'(BYTES)) |=> (rd_valid && rd_fault));

  // R3: response only after a request
  assert_rd_cause_R3: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en));

  // R7: tick without a store clears the word
  assert_tick_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (tick && !(wr_en && good_size)) |=> (mbox_q == '0));

  // R8: bad-size store leaves the word alone
  assert_bad_size_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !good_size && !tick) |=> $stable(mbox_q));
endmodule

bind hostmbox_port hostmbox_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_size   (wr_size),
  .wr_data   (wr_data),
  .rd_en     (rd_en),
  .rd_size   (rd_size),
  .tick      (tick),
  .rd_valid  (rd_valid),
  .rd_fault  (rd_fault),
  .exit_done (exit_done),
  .con_valid (con_valid),
  .con_byte  (con_byte),
  .mbox_q    (mbox_q)
);

// File: tb/sim_hostmbox_port.sv
`timescale 1ns/1ps
module sim_hostmbox_port;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [3:0]  wr_size;
  logic [63:0] wr_data;
  logic        rd_en;
  logic [3:0]  rd_size;
  logic        tick;
  logic        rd_valid;
  logic [63:0] rd_data;
  logic        rd_fault;
  logic        exit_done;
  logic [46:0] exit_code;
  logic        con_valid;
  logic [7:0]  con_byte;

  int checks = 0;
  int fails  = 0;

  logic [63:0] m_word;
  logic        m_done;
  logic [46:0] m_code;

  always #5 clk = ~clk;

  hostmbox_port u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_size(wr_size), .wr_data(wr_data),
    .rd_en(rd_en), .rd_size(rd_size), .tick(tick),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_fault(rd_fault),
    .exit_done(exit_done), .exit_code(exit_code),
    .con_valid(con_valid), .con_byte(con_byte)
  );

  function automatic logic [63:0] zext(input logic [3:0] sz, input logic [63:0] d);
    logic [63:0] r = '0;
    for (int i = 0; i < 8; i++) if (i < int'(sz)) r[i*8 +: 8] = d[i*8 +: 8];
    return r;
  endfunction

  function automatic bit sz_ok(input logic [3:0] sz);
    return sz >= 4'd1 && sz <= 4'd8;
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit we, input logic [3:0] ws, input logic [63:0] wd,
                      input bit re, input logic [3:0] rs, input bit tk);
    logic        e_rv, e_rf, e_cv;
    logic [63:0] e_rd, w;
    logic [7:0]  e_cb;
    wr_en = we; wr_size = ws; wr_data = wd; rd_en = re; rd_size = rs; tick = tk;
    e_rv = re;
    e_rf = re && rs != 4'd8;
    e_rd = (re && rs == 4'd8) ? m_word : 64'h0;
    e_cv = 1'b0; e_cb = 8'h00;
    if (we && sz_ok(ws)) begin
      w = zext(ws, wd);
      m_word = w;
      if (w[63:56] == 8'h00 && w[0]) begin m_done = 1'b1; m_code = w[47:1]; end
      if (w[63:56] == 8'h01 && w[55:48] == 8'h01) begin e_cv = 1'b1; e_cb = w[7:0]; end
    end else if (tk) begin
      m_word = 64'h0;
    end
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; rd_en = 0; tick = 0;
    chk(tag, "rd_valid", 64'(rd_valid), 64'(e_rv));
    chk(tag, "rd_fault", 64'(rd_fault), 64'(e_rf));
    chk(tag, "rd_data", rd_data, e_rd);
    chk(tag, "con_valid", 64'(con_valid), 64'(e_cv));
    if (e_cv) chk(tag, "con_byte", 64'(con_byte), 64'(e_cb));
    chk(tag, "exit_done", 64'(exit_done), 64'(m_done));
    chk(tag, "exit_code", 64'(exit_code), 64'(m_code));
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 4'd0, 64'h0, 0, 4'd0, 0);
  endtask

  task automatic peek(input string tag);
    step(tag, 0, 4'd0, 64'h0, 1, 4'd8, 0);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] d;
    int unsigned seed;
    seed = 32'd20240;
    d = 64'($urandom(seed));
    m_word = '0; m_done = 0; m_code = '0;
    rst = 1; wr_en = 0; wr_size = 0; wr_data = 0; rd_en = 0; rd_size = 0; tick = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    idle("R1");
    peek("R1");

    // R2: zero extension of narrow stores
    step("R2", 1, 4'd2, 64'hFFFF_FFFF_FFFF_1234, 0, 4'd0, 0);
    peek("R2");
    step("R2", 1, 4'd8, 64'h0000_1234_5678_9ABC, 0, 4'd0, 0);
    peek("R2");
    // R3: narrow loads fault
    step("R3", 0, 4'd0, 64'h0, 1, 4'd4, 0);
    step("R3", 0, 4'd0, 64'h0, 1, 4'd1, 0);
    step("R3", 0, 4'd0, 64'h0, 1, 4'd0, 0);
    // R4: exit via one-byte store with upper garbage
    step("R4", 1, 4'd1, 64'hDEAD_BEEF_CAFE_01A5, 0, 4'd0, 0);
    idle("R4");
    // R5: back-to-back console writes, then drop
    step("R5", 1, 4'd8, 64'h0101_0000_0000_0041, 0, 4'd0, 0);
    step("R5", 1, 4'd8, 64'h0101_0000_0000_0042, 0, 4'd0, 0);
    idle("R5");
    // R6: accepted without action
    step("R6", 1, 4'd8, 64'h0100_0000_0000_0043, 0, 4'd0, 0);
    peek("R6");
    step("R6", 1, 4'd8, 64'h0107_0000_0000_0044, 0, 4'd0, 0);
    step("R6", 1, 4'd8, 64'h0701_0000_0000_0045, 0, 4'd0, 0);
    peek("R6");
    // R7: tick clears; store beats tick
    step("R7", 0, 4'd0, 64'h0, 0, 4'd0, 1);
    peek("R7");
    step("R7", 1, 4'd8, 64'h0200_0000_0000_0077, 0, 4'd0, 1);
    peek("R7");
    // R8: bad sizes ignored
    step("R8", 1, 4'd0, 64'h0000_0000_0000_0001, 0, 4'd0, 0);
    step("R8", 1, 4'd9, 64'h0101_0000_0000_0055, 0, 4'd0, 0);
    peek("R8");
    // R9: sticky done, code replaced, non-exit leaves it
    step("R9", 1, 4'd8, 64'h0000_0000_0000_0011, 0, 4'd0, 0);
    step("R9", 1, 4'd8, 64'h0000_0000_0000_0F00, 0, 4'd0, 0);
    idle("R9");
    // R10: load alongside store sees old word
    step("R10", 1, 4'd8, 64'h0300_1111_2222_3333, 1, 4'd8, 0);
    peek("R10");

    for (int i = 0; i < 500; i++) begin
      logic [7:0]  dv, cm;
      logic [3:0]  ws;
      int unsigned p;
      p = $urandom % 4;
      dv = (p == 0) ? 8'h00 : (p == 1) ? 8'h01 : 8'($urandom);
      p = $urandom % 3;
      cm = (p == 0) ? 8'h00 : (p == 1) ? 8'h01 : 8'($urandom);
      d = {dv, cm, 16'($urandom), 32'($urandom)};
      p = $urandom % 4;
      ws = (p < 2) ? 4'd8 : 4'($urandom % 10);
      step("R6", ($urandom % 2) == 0, ws, d, ($urandom % 2) == 0,
           (($urandom % 3) == 0) ? 4'($urandom % 9) : 4'd8, ($urandom % 6) == 0);
    end

    summary();
    $finish;
  end
endmodule